// File: doc/BRIEF.md
# Two-Stage Load-Balancing Time-Division Crossbar

This core switches fixed-length packets between eight ports in fixed time slots of 32 cycles. At 16 bits per cycle, one 64-byte packet fills one slot. The first stage spreads the packets from each input across the eight middle ports with a rotation that advances once per slot. Consecutive packets from one source therefore land on different middle ports. Each packet that leaves the first stage carries a valid flag, its destination port and a sequence number. That number counts packets per source and destination pair.

The middle ports leave the block and come back in. In the complete fabric a resequencing and output-buffer layer sits on that path; in the bench it is a plain wire. The second stage maps middle ports onto output ports. It takes its permutation for each slot from an eight-entry schedule table, indexed by slot number, that software or a neighbouring block writes. Both stages sample packet headers (valid and destination) only in the first cycle of a slot. They carry data through in the same cycle it arrives, and they change permutation only on a slot boundary.

Top module: `tdm_lb_switch`

## Requirements
- R1: A slot lasts 32 cycles. `slot_first_o` is high exactly in cycle 0 of every slot, and the first cycle after reset is cycle 0 of slot 0. The slot number counts 0..7 and advances by one (mod 8) at each slot boundary.
- R2: In slot number t, each data word on input i appears in the same cycle on middle port (i + t) mod 8.
- R3: Each input's valid and destination are sampled in cycle 0 of a slot. Changes on `in_valid_i`/`in_dest_i` in cycles 1..31 are ignored. The middle port carries the sampled values for the whole slot.
- R4: The sequence number on a valid middle-port packet is the current value of an 8-bit counter kept for each (input, destination) pair. The counter resets to 0, advances by one for each valid packet from that input to that destination, and wraps from 255 to 0. Idle slots leave it unchanged.
- R5: In a slot with number s, middle port m is connected to output `table[s mod 8][m]`. Bits [3m+2:3m] of a table entry hold the target output of middle port m. After reset every entry is the identity map.
- R6: A table write (`sched_we_i`, `sched_addr_i`, `sched_data_i`) in any cycle is used by every slot that begins after that cycle. This includes a write made in cycle 31 of the slot just before. A write made during a slot never alters the connections of that slot.
- R7: When several middle ports target the same output, the lowest-numbered one is connected and the others are dropped.
- R8: `out_sop_o` of an output is high only in cycle 0 of a slot and only when that output's packet is valid. An output with no middle port mapped to it drives valid 0, data 0 and destination 0.
- R9: The second stage samples `mid_valid_i`/`mid_dest_i` in cycle 0 of a slot and ignores them in cycles 1..31. An output carries the valid flag and destination of the middle port connected to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8x16 | Packet data word per input |
| in_valid_i | input | 8 | Packet present on input (sampled in cycle 0) |
| in_dest_i | input | 8x3 | Destination port per input (sampled in cycle 0) |
| mid_data_o | output | 8x16 | Spread data per middle port |
| mid_valid_o | output | 8 | Packet valid per middle port |
| mid_dest_o | output | 8x3 | Destination tag per middle port |
| mid_seq_o | output | 8x8 | Sequence number per middle port |
| mid_data_i | input | 8x16 | Data returning from the buffer layer |
| mid_valid_i | input | 8 | Valid returning from the buffer layer |
| mid_dest_i | input | 8x3 | Destination returning from the buffer layer |
| sched_we_i | input | 1 | Schedule table write strobe |
| sched_addr_i | input | 3 | Table entry to write |
| sched_data_i | input | 8x3 | New entry, target output per middle port |
| out_data_o | output | 8x16 | Data per output port |
| out_valid_o | output | 8 | Valid per output port |
| out_sop_o | output | 8 | Start of packet per output port |
| out_dest_o | output | 8x3 | Destination tag per output port |
| slot_first_o | output | 1 | High in cycle 0 of each slot |

## Verification
The risky overlap is a schedule write that lands in the same cycle as a slot boundary: the write in cycle 31 and the load of the next slot's permutation happen on the same clock edge. A second overlap is a write, made mid-slot, to the entry that is currently in use. The bench provokes both on purpose, and random writes also fall in cycle 31 and on the active entry. The bench model then applies a write only to the table and takes the next slot's permutation from the table as it stands after cycle 31. Every output word of the following slot is compared against that model, and many of those entries map two middle ports to one output.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned PORTS_DEF  = 8;
  localparam int unsigned WORD_DEF   = 16;
  localparam int unsigned SEQ_DEF    = 8;
  localparam int unsigned SLOT_DEF   = 32;
  localparam int unsigned SCHED_DEF  = 8;

  function automatic int unsigned rot_src(int unsigned mid, int unsigned rot, int unsigned n);
    return (mid + n - (rot % n)) % n;
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned SLOT_CYCLES = 32,
  parameter int unsigned SCHED_DEPTH = 8,
  localparam int unsigned CW = $clog2(SLOT_CYCLES),
  localparam int unsigned SW = $clog2(SCHED_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          first_o,
  output logic          last_o,
  output logic [SW-1:0] slot_o
);
  logic [CW-1:0] cyc_q;
  logic [SW-1:0] slot_q;

  assign first_o = (cyc_q == '0);
  assign last_o  = (cyc_q == CW'(SLOT_CYCLES - 1));
  assign slot_o  = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (last_o) begin
      cyc_q  <= '0;
      slot_q <= (slot_q == SW'(SCHED_DEPTH - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> first_o);
  // R1
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_o |-> $stable(slot_o));
endmodule

// File: rtl/tdm_spread_stage.sv
module tdm_spread_stage #(
  parameter int unsigned N      = 8,
  parameter int unsigned W      = 16,
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned SW     = 3,
  localparam int unsigned DW    = $clog2(N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     first_i,
  input  logic [SW-1:0]            slot_i,
  input  logic [N-1:0][W-1:0]      in_data_i,
  input  logic [N-1:0]             in_valid_i,
  input  logic [N-1:0][DW-1:0]     in_dest_i,
  output logic [N-1:0][W-1:0]      mid_data_o,
  output logic [N-1:0]             mid_valid_o,
  output logic [N-1:0][DW-1:0]     mid_dest_o,
  output logic [N-1:0][SEQ_W-1:0]  mid_seq_o
);
  import tdm_pkg::*;

  logic [N-1:0]            vld_q, vld_e;
  logic [N-1:0][DW-1:0]    dst_q, dst_e;
  logic [N-1:0][SEQ_W-1:0] seq_q, seq_e, cur_seq;

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0][SEQ_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (first_i && in_valid_i[i])
        cnt_q[in_dest_i[i]] <= cnt_q[in_dest_i[i]] + 1'b1;
    end

    assign cur_seq[i] = cnt_q[in_dest_i[i]];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      vld_e[i] = first_i ? in_valid_i[i] : vld_q[i];
      dst_e[i] = first_i ? in_dest_i[i]  : dst_q[i];
      seq_e[i] = first_i ? cur_seq[i]    : seq_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dst_q <= '0;
      seq_q <= '0;
    end else if (first_i) begin
      vld_q <= in_valid_i;
      dst_q <= in_dest_i;
      seq_q <= cur_seq;
    end
  end

  // rotation: middle m is fed by input (m - slot) mod N
  always_comb begin
    logic [DW-1:0] src;
    for (int m = 0; m < N; m++) begin
      src            = DW'(rot_src(m, int'(slot_i), N));
      mid_data_o[m]  = in_data_i[src];
      mid_valid_o[m] = vld_e[src];
      mid_dest_o[m]  = dst_e[src];
      mid_seq_o[m]   = seq_e[src];
    end
  end

  // R2
  valid_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mid_valid_o) == $countones(vld_e));
  // R3
  hdr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_i |-> ($stable(mid_valid_o) && $stable(mid_dest_o)));
endmodule

// File: rtl/tdm_sched_stage.sv
module tdm_sched_stage #(
  parameter int unsigned N      = 8,
  parameter int unsigned W      = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SW     = 3,
  localparam int unsigned DW    = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  first_i,
  input  logic                  last_i,
  input  logic [SW-1:0]         slot_i,
  input  logic                  sched_we_i,
  input  logic [SW-1:0]         sched_addr_i,
  input  logic [N-1:0][DW-1:0]  sched_data_i,
  input  logic [N-1:0][W-1:0]   mid_data_i,
  input  logic [N-1:0]          mid_valid_i,
  input  logic [N-1:0][DW-1:0]  mid_dest_i,
  output logic [N-1:0][W-1:0]   out_data_o,
  output logic [N-1:0]          out_valid_o,
  output logic [N-1:0]          out_sop_o,
  output logic [N-1:0][DW-1:0]  out_dest_o
);
  logic [DEPTH-1:0][N-1:0][DW-1:0] tbl_q;
  logic [N-1:0][DW-1:0]            perm_q;
  logic [N-1:0]                    vld_q, vld_e;
  logic [N-1:0][DW-1:0]            dst_q, dst_e;
  logic [SW-1:0]                   nxt_idx;
  logic                            wr_ok;

  assign nxt_idx = (slot_i == SW'(DEPTH - 1)) ? '0 : slot_i + 1'b1;
  assign wr_ok   = sched_we_i && (int'(sched_addr_i) < DEPTH);
  assign vld_e   = first_i ? mid_valid_i : vld_q;
  assign dst_e   = first_i ? mid_dest_i  : dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++)
        for (int m = 0; m < N; m++)
          tbl_q[e][m] <= DW'(m);
      for (int m = 0; m < N; m++)
        perm_q[m] <= DW'(m);
      vld_q <= '0;
      dst_q <= '0;
    end else begin
      if (wr_ok) tbl_q[sched_addr_i] <= sched_data_i;
      // same-edge write to the next entry is forwarded
      if (last_i)
        perm_q <= (wr_ok && sched_addr_i == nxt_idx) ? sched_data_i : tbl_q[nxt_idx];
      if (first_i) begin
        vld_q <= mid_valid_i;
        dst_q <= mid_dest_i;
      end
    end
  end

  // descending scan: lowest middle port claiming an output wins
  always_comb begin
    out_data_o  = '0;
    out_valid_o = '0;
    out_dest_o  = '0;
    for (int o = 0; o < N; o++) begin
      for (int m = N - 1; m >= 0; m--) begin
        if (perm_q[m] == DW'(o)) begin
          out_data_o[o]  = mid_data_i[m];
          out_valid_o[o] = vld_e[m];
          out_dest_o[o]  = dst_e[m];
        end
      end
    end
  end

  assign out_sop_o = first_i ? out_valid_o : '0;

  // R8
  sop_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|out_sop_o) |-> first_i);
  // R7
  out_valid_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(out_valid_o) <= $countones(vld_e));
  // R6
  perm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_i |-> $stable(perm_q));
endmodule

// File: rtl/tdm_lb_switch.sv
module tdm_lb_switch #(
  parameter int unsigned N_PORTS     = tdm_pkg::PORTS_DEF,
  parameter int unsigned DATA_W      = tdm_pkg::WORD_DEF,
  parameter int unsigned SEQ_W       = tdm_pkg::SEQ_DEF,
  parameter int unsigned SLOT_CYCLES = tdm_pkg::SLOT_DEF,
  parameter int unsigned SCHED_DEPTH = tdm_pkg::SCHED_DEF,
  localparam int unsigned DEST_W     = $clog2(N_PORTS),
  localparam int unsigned SLOT_W     = $clog2(SCHED_DEPTH)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_PORTS-1:0][DATA_W-1:0]    in_data_i,
  input  logic [N_PORTS-1:0]                in_valid_i,
  input  logic [N_PORTS-1:0][DEST_W-1:0]    in_dest_i,
  output logic [N_PORTS-1:0][DATA_W-1:0]    mid_data_o,
  output logic [N_PORTS-1:0]                mid_valid_o,
  output logic [N_PORTS-1:0][DEST_W-1:0]    mid_dest_o,
  output logic [N_PORTS-1:0][SEQ_W-1:0]     mid_seq_o,
  input  logic [N_PORTS-1:0][DATA_W-1:0]    mid_data_i,
  input  logic [N_PORTS-1:0]                mid_valid_i,
  input  logic [N_PORTS-1:0][DEST_W-1:0]    mid_dest_i,
  input  logic                              sched_we_i,
  input  logic [SLOT_W-1:0]                 sched_addr_i,
  input  logic [N_PORTS-1:0][DEST_W-1:0]    sched_data_i,
  output logic [N_PORTS-1:0][DATA_W-1:0]    out_data_o,
  output logic [N_PORTS-1:0]                out_valid_o,
  output logic [N_PORTS-1:0]                out_sop_o,
  output logic [N_PORTS-1:0][DEST_W-1:0]    out_dest_o,
  output logic                              slot_first_o
);
  logic              first, last;
  logic [SLOT_W-1:0] slot;

  tdm_slot_timer #(
    .SLOT_CYCLES (SLOT_CYCLES),
    .SCHED_DEPTH (SCHED_DEPTH)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .first_o (first),
    .last_o  (last),
    .slot_o  (slot)
  );

  tdm_spread_stage #(
    .N     (N_PORTS),
    .W     (DATA_W),
    .SEQ_W (SEQ_W),
    .SW    (SLOT_W)
  ) u_spread (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .first_i     (first),
    .slot_i      (slot),
    .in_data_i   (in_data_i),
    .in_valid_i  (in_valid_i),
    .in_dest_i   (in_dest_i),
    .mid_data_o  (mid_data_o),
    .mid_valid_o (mid_valid_o),
    .mid_dest_o  (mid_dest_o),
    .mid_seq_o   (mid_seq_o)
  );

  tdm_sched_stage #(
    .N     (N_PORTS),
    .W     (DATA_W),
    .DEPTH (SCHED_DEPTH),
    .SW    (SLOT_W)
  ) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .first_i      (first),
    .last_i       (last),
    .slot_i       (slot),
    .sched_we_i   (sched_we_i),
    .sched_addr_i (sched_addr_i),
    .sched_data_i (sched_data_i),
    .mid_data_i   (mid_data_i),
    .mid_valid_i  (mid_valid_i),
    .mid_dest_i   (mid_dest_i),
    .out_data_o   (out_data_o),
    .out_valid_o  (out_valid_o),
    .out_sop_o    (out_sop_o),
    .out_dest_o   (out_dest_o)
  );

  assign slot_first_o = first;
endmodule

// File: tb/sim_tdm_lb_switch.sv
module sim_tdm_lb_switch;
  localparam int N = 8, W = 16, DW = 3, SQ = 8, SC = 32, D = 8;

  logic                   clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0][W-1:0]    in_data_i = '0, mid_data_i = '0;
  logic [N-1:0]           in_valid_i = '0, mid_valid_i = '0;
  logic [N-1:0][DW-1:0]   in_dest_i = '0, mid_dest_i = '0, sched_data_i = '0;
  logic                   sched_we_i = 1'b0;
  logic [2:0]             sched_addr_i = '0;
  logic [N-1:0][W-1:0]    mid_data_o, out_data_o;
  logic [N-1:0]           mid_valid_o, out_valid_o, out_sop_o;
  logic [N-1:0][DW-1:0]   mid_dest_o, out_dest_o;
  logic [N-1:0][SQ-1:0]   mid_seq_o;
  logic                   slot_first_o;

  tdm_lb_switch u0 (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int exp_seq [N][N];
  int tbl [D][N];
  int cur_perm [N];
  int slot = 0;
  bit hv [N];
  int hd [N], hs [N];
  bit nxt_valid [N];
  int nxt_dest [N];
  int wr_cyc = -1, wr_addr = 0;
  int wr_perm [N];
  string map_tag = "R5";

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_slot();
    for (int c = 0; c < SC; c++) begin
      for (int i = 0; i < N; i++) begin
        in_data_i[i] = 16'($urandom());
        if (c == 0) begin
          in_valid_i[i] = nxt_valid[i];
          in_dest_i[i]  = 3'(nxt_dest[i]);
        end else begin
          in_valid_i[i] = 1'($urandom());  // R3: must be ignored
          in_dest_i[i]  = 3'($urandom());
        end
      end
      sched_we_i = (c == wr_cyc);
      sched_addr_i = 3'(wr_addr);
      for (int m = 0; m < N; m++) sched_data_i[m] = 3'(wr_perm[m]);
      #1;
      mid_data_i = mid_data_o;
      if (c == 0) begin
        mid_valid_i = mid_valid_o;
        mid_dest_i  = mid_dest_o;
      end else begin
        mid_valid_i = N'($urandom());   // R9: must be ignored
        mid_dest_i  = 24'($urandom());
      end
      #1;
      if (c == 0)
        for (int i = 0; i < N; i++) begin
          hv[i] = nxt_valid[i];
          hd[i] = nxt_dest[i];
          hs[i] = exp_seq[i][hd[i]];
          if (hv[i]) exp_seq[i][hd[i]] = (exp_seq[i][hd[i]] + 1) % 256;
        end
      chk(slot_first_o == (c == 0), "R1 slot_first", slot_first_o, c == 0);
      for (int m = 0; m < N; m++) begin
        int s;
        s = (m + N - (slot % N)) % N;
        chk(mid_data_o[m] == in_data_i[s], "R2 mid data", mid_data_o[m], in_data_i[s]);
        chk(mid_valid_o[m] == hv[s], "R3 mid valid", mid_valid_o[m], hv[s]);
        if (hv[s]) begin
          chk(mid_dest_o[m] == 3'(hd[s]), "R3 mid dest", mid_dest_o[m], hd[s]);
          chk(mid_seq_o[m] == 8'(hs[s]), "R4 seq id", mid_seq_o[m], hs[s]);
        end
      end
      for (int o = 0; o < N; o++) begin
        int sel;
        sel = -1;
        for (int m = N - 1; m >= 0; m--) if (cur_perm[m] == o) sel = m;
        if (sel < 0) begin
          chk(out_valid_o[o] == 0 && out_data_o[o] == 0 && out_dest_o[o] == 0,
              "R8 unmapped output", {out_valid_o[o], out_data_o[o]}, 0);
        end else begin
          int s;
          bit ev;
          s  = (sel + N - (slot % N)) % N;
          ev = hv[s];
          chk(out_data_o[o] == in_data_i[s], map_tag, out_data_o[o], in_data_i[s]);
          chk(out_valid_o[o] == ev, "R9 out valid", out_valid_o[o], ev);
          if (ev) chk(out_dest_o[o] == 3'(hd[s]), "R9 out dest", out_dest_o[o], hd[s]);
        end
        chk(out_sop_o[o] == (c == 0 && sel >= 0 && hv[(sel + N - (slot % N)) % N]),
            "R8 sop", out_sop_o[o], out_sop_o[o] ^ 1'b1);
      end
      if (c == wr_cyc) for (int m = 0; m < N; m++) tbl[wr_addr][m] = wr_perm[m];
      @(negedge clk_i);
    end
    sched_we_i = 1'b0;
    wr_cyc = -1;
    slot = (slot + 1) % D;
    for (int m = 0; m < N; m++) cur_perm[m] = tbl[slot][m];
  endtask

  task automatic rand_perm(bit allow_dup);
    for (int m = 0; m < N; m++) wr_perm[m] = allow_dup ? int'($urandom_range(N - 1)) : m;
    if (!allow_dup)
      for (int m = N - 1; m > 0; m--) begin
        int j, t;
        j = $urandom_range(m);
        t = wr_perm[m]; wr_perm[m] = wr_perm[j]; wr_perm[j] = t;
      end
  endtask

  task automatic rand_hdr();
    for (int i = 0; i < N; i++) begin
      nxt_valid[i] = ($urandom_range(3) != 0);
      nxt_dest[i]  = $urandom_range(N - 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired act=hang exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int e = 0; e < D; e++) for (int m = 0; m < N; m++) tbl[e][m] = m;
    for (int i = 0; i < N; i++) for (int d = 0; d < N; d++) exp_seq[i][d] = 0;
    for (int m = 0; m < N; m++) cur_perm[m] = m;
    repeat (3) @(negedge clk_i);
    #1;
    chk(slot_first_o == 1'b1, "R1 reset slot_first", slot_first_o, 1);
    chk(out_valid_o == '0, "R8 reset out valid", out_valid_o, 0);
    chk(mid_valid_o == '0, "R3 reset mid valid", mid_valid_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // full load, dest = own index
    for (int i = 0; i < N; i++) begin nxt_valid[i] = 1; nxt_dest[i] = i; end
    run_slot();
    // idle slot: R8 no sop, R4 no counter advance
    for (int i = 0; i < N; i++) nxt_valid[i] = 0;
    run_slot();
    // R6: write to the entry in use mid-slot (no effect this slot)
    for (int i = 0; i < N; i++) nxt_valid[i] = 1;
    map_tag = "R6 in-use write";
    wr_cyc = 5; wr_addr = slot;
    for (int m = 0; m < N; m++) wr_perm[m] = N - 1 - m;
    run_slot();
    // R6: write next entry in the boundary cycle
    wr_cyc = SC - 1; wr_addr = (slot + 1) % D;
    for (int m = 0; m < N; m++) wr_perm[m] = (m + 3) % N;
    run_slot();
    run_slot();
    // R7: every middle port to output 0
    map_tag = "R7 collision";
    wr_cyc = SC - 1; wr_addr = (slot + 1) % D;
    for (int m = 0; m < N; m++) wr_perm[m] = 0;
    run_slot();
    run_slot();

    // random traffic and schedule writes
    map_tag = "R5 R6 R7 random";
    for (int k = 0; k < 200; k++) begin
      rand_hdr();
      if ($urandom_range(3) == 0) begin
        int pick;
        pick = $urandom_range(3);
        wr_cyc  = (pick == 0) ? SC - 1 : int'($urandom_range(SC - 1));
        wr_addr = (pick == 1) ? slot : (pick == 2) ? (slot + 1) % D : int'($urandom_range(D - 1));
        rand_perm($urandom_range(2) == 0);
      end
      run_slot();
    end

    // R4 wrap: input 0 to dest 5 for more than 256 packets
    map_tag = "R5";
    for (int k = 0; k < 260; k++) begin
      rand_hdr();
      nxt_valid[0] = 1; nxt_dest[0] = 5;
      run_slot();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule